// File: doc/BRIEF.md
# Bit-Serial Synchronous Character Receiver with Pattern Hunt

This block receives a serial bit stream timed by a clock that arrives with the data. The block's own clock is that receive clock: one data bit is taken from `rxd` on every rising edge. No start or stop bits frame the characters. Instead the receiver looks for a programmable synchronisation pattern. Until it finds that pattern it is in hunt mode and produces nothing. While hunting it tests every bit position, so the pattern is found at any alignment.

Once locked, the receiver cuts the stream into back-to-back characters of `CHAR_W` bits. The first bit received becomes bit 0. A character that equals the sync pattern or the programmable end code is not passed on as data, and the receiver drops back to hunt mode. An end code also gives a single-cycle end strobe. Software can force the receiver back to hunting at any moment with a one-cycle command. That command also throws away any character that is only partly assembled.

Top module: `sync_hunt_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `in_sync`, `char_valid` and `eot_stb` are 0.
- R2: In hunt mode, the pattern in `sync_pat` is compared against the last `CHAR_W` received bits on every bit, at any alignment. `in_sync` reads 1 from the cycle after the edge that samples the last sync bit.
- R3: Bits are received least significant first: the first bit after a character boundary appears on `char_data[0]`, and the last one on `char_data[CHAR_W-1]`.
- R4: In sync mode every `CHAR_W` bits form one character. Each character gives `char_valid` high for one cycle, in the cycle after its last bit is sampled. Consecutive characters have no gap bits, so their strobes are exactly `CHAR_W` cycles apart.
- R5: In sync mode, the sync and end codes are recognised only at character boundaries. A sync pattern that straddles two characters is delivered as two ordinary data characters.
- R6: A character equal to `sync_pat` at a boundary is not delivered, and the receiver returns to hunt mode (`in_sync` 0). A run of repeated sync characters therefore relocks on every second one, and data following an odd-length run is delivered.
- R7: A character equal to `eot_code` at a boundary is not delivered. It gives `eot_stb` high for exactly one cycle, never together with `char_valid`, and `in_sync` falls in the same cycle.
- R8: A `hunt_cmd` pulse forces hunt mode in the next cycle, whatever the state. If it coincides with the last bit of a character, it wins: that character gives neither `char_valid` nor `eot_stb`, and any partial character is discarded.
- R9: When `sync_pat` equals `eot_code`, a boundary character with that value is treated as sync: no `eot_stb`, return to hunt.
- R10: In hunt mode neither `char_valid` nor `eot_stb` is ever raised, even when the stream carries the end code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; `rxd` is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive data |
| hunt_cmd | input | 1 | One-cycle command forcing hunt mode |
| sync_pat | input | CHAR_W | Synchronisation pattern |
| eot_code | input | CHAR_W | End-of-text character code |
| char_data | output | CHAR_W | Last assembled data character |
| char_valid | output | 1 | One-cycle strobe: `char_data` holds a new character |
| eot_stb | output | 1 | One-cycle strobe: end code received |
| in_sync | output | 1 | 1 in sync mode, 0 in hunt mode |

## Verification
Two functions can collide in one cycle: a software hunt command and the completion of a character at a boundary. The bench provokes this by raising `hunt_cmd` on the very bit that completes an end-code character. It judges the result by the absence of any end or data strobe and by `in_sync` reading 0 right after that edge. A second collision is the sync and end codes configured to the same value. In that case the bench sends the shared code at a boundary and checks that the receiver only drops to hunt mode, with no end strobe.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic {
        MODE_HUNT = 1'b0,
        MODE_SYNC = 1'b1
    } shr_mode_e;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_LOCK   = 3'd1,
        EV_DATA   = 3'd2,
        EV_EOT    = 3'd3,
        EV_RESYNC = 3'd4,
        EV_ABORT  = 3'd5
    } shr_event_e;

    // Priority: software hunt, then sync, then end code, then data.
    function automatic shr_event_e shr_decide(
        input shr_mode_e mode,
        input logic      force_hunt,
        input logic      at_bnd,
        input logic      hit_sync,
        input logic      hit_eot
    );
        if (force_hunt)             return EV_ABORT;
        if (mode == MODE_HUNT)      return hit_sync ? EV_LOCK : EV_NONE;
        if (!at_bnd)                return EV_NONE;
        if (hit_sync)               return EV_RESYNC;
        if (hit_eot)                return EV_EOT;
        return EV_DATA;
    endfunction

endpackage

// File: rtl/shr_shifter.sv
module shr_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_in,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win_q;

    // Newest bit enters at the top, so the oldest bit sits at bit 0.
    assign win_next = {bit_in, win_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_next;
    end
endmodule

// File: rtl/shr_matcher.sv
module shr_matcher #(
    parameter int W = 8
) (
    input  logic [W-1:0] win,
    input  logic [W-1:0] sync_pat,
    input  logic [W-1:0] eot_code,
    output logic         hit_sync,
    output logic         hit_eot
);
    logic [W-1:0] diff_sync;
    logic [W-1:0] diff_eot;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff_sync[i] = win[i] ^ sync_pat[i];
        assign diff_eot[i]  = win[i] ^ eot_code[i];
    end

    assign hit_sync = ~|diff_sync;
    assign hit_eot  = ~|diff_eot;
endmodule

// File: rtl/shr_bitcnt.sv
module shr_bitcnt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic at_bnd
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;

    assign at_bnd = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (at_bnd)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    AST_BND_SPACED: assert property (@(posedge clk) disable iff (rst)
        at_bnd |=> !at_bnd); // R4
endmodule

// File: rtl/shr_ctrl.sv
module shr_ctrl
    import shr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  shr_event_e   ev,
    input  logic [W-1:0] win,
    output shr_mode_e    mode_q,
    output logic [W-1:0] char_data,
    output logic         char_valid,
    output logic         eot_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_HUNT;
            char_data  <= '0;
            char_valid <= 1'b0;
            eot_stb    <= 1'b0;
        end else begin
            char_valid <= (ev == EV_DATA);
            eot_stb    <= (ev == EV_EOT);
            if (ev == EV_DATA) char_data <= win;
            case (ev)
                EV_LOCK:                      mode_q <= MODE_SYNC;
                EV_RESYNC, EV_EOT, EV_ABORT:  mode_q <= MODE_HUNT;
                default:                      mode_q <= mode_q;
            endcase
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(char_valid && eot_stb)); // R7
    AST_EOT_DROPS: assert property (@(posedge clk) disable iff (rst)
        eot_stb |-> (mode_q == MODE_HUNT)); // R7
    AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eot_stb |=> !eot_stb); // R7
    AST_VALID_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> (mode_q == MODE_SYNC)); // R4
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
    import shr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              hunt_cmd,
    input  logic [CHAR_W-1:0] sync_pat,
    input  logic [CHAR_W-1:0] eot_code,
    output logic [CHAR_W-1:0] char_data,
    output logic              char_valid,
    output logic              eot_stb,
    output logic              in_sync
);
    logic [CHAR_W-1:0] win_next;
    logic              hit_sync;
    logic              hit_eot;
    logic              at_bnd;
    logic              cnt_run;
    shr_mode_e         mode_q;
    shr_event_e        ev;

    shr_shifter #(.W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (rxd),
        .win_next (win_next)
    );

    shr_matcher #(.W(CHAR_W)) u_match (
        .win      (win_next),
        .sync_pat (sync_pat),
        .eot_code (eot_code),
        .hit_sync (hit_sync),
        .hit_eot  (hit_eot)
    );

    assign cnt_run = (mode_q == MODE_SYNC) && !hunt_cmd;

    shr_bitcnt #(.W(CHAR_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (cnt_run),
        .at_bnd (at_bnd)
    );

    assign ev = shr_decide(mode_q, hunt_cmd, at_bnd, hit_sync, hit_eot);

    shr_ctrl #(.W(CHAR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .win        (win_next),
        .mode_q     (mode_q),
        .char_data  (char_data),
        .char_valid (char_valid),
        .eot_stb    (eot_stb)
    );

    assign in_sync = (mode_q == MODE_SYNC);

    AST_HUNT_CMD: assert property (@(posedge clk) disable iff (rst)
        hunt_cmd |=> (!in_sync && !char_valid && !eot_stb)); // R8
    AST_NO_OUT_IN_HUNT: assert property (@(posedge clk) disable iff (rst)
        !in_sync |=> (!char_valid && !eot_stb)); // R10
endmodule

// File: tb/sync_hunt_rx_tb_top.sv
`timescale 1ns/1ps
module sync_hunt_rx_tb_top;
    localparam int W = 8;
    localparam logic [W-1:0] SYN = 8'h16;
    localparam logic [W-1:0] EOT = 8'h04;

    logic         clk = 1'b0;
    logic         rst;
    logic         rxd;
    logic         hunt_cmd;
    logic [W-1:0] sync_pat;
    logic [W-1:0] eot_code;
    logic [W-1:0] char_data;
    logic         char_valid;
    logic         eot_stb;
    logic         in_sync;

    always #2.5 clk = ~clk;

    sync_hunt_rx #(.CHAR_W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .rxd        (rxd),
        .hunt_cmd   (hunt_cmd),
        .sync_pat   (sync_pat),
        .eot_code   (eot_code),
        .char_data  (char_data),
        .char_valid (char_valid),
        .eot_stb    (eot_stb),
        .in_sync    (in_sync)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    last_cyc = 0;
    bit    done = 0;

    // Expected item: {back_to_back, is_eot, data}
    logic [W+1:0] exp_q[$];
    string        tag_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every output strobe.
    always @(negedge clk) begin
        logic [W+1:0] e;
        string        t;
        cyc++;
        if (!rst && (char_valid || eot_stb)) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R10: actual valid=%b eot=%b data=%h expected no output",
                         char_valid, eot_stb, char_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " strobe kind"}, {31'd0, eot_stb}, {31'd0, e[W]});
                check({t, " strobe excl R7"}, {31'd0, char_valid && eot_stb}, 32'd0);
                if (!e[W]) check({t, " data"}, {24'd0, char_data}, {24'd0, e[W-1:0]});
                if (e[W+1]) check("R4 spacing", cyc - last_cyc, W);
                last_cyc = cyc;
            end
        end
    end

    task automatic send_bit(input logic b, input logic hc);
        @(negedge clk);
        rxd      = b;
        hunt_cmd = hc;
    endtask

    task automatic send_byte(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) send_bit(v[i], 1'b0);
    endtask

    task automatic send_byte_hc(input logic [W-1:0] v, input int hc_bit);
        for (int i = 0; i < W; i++) send_bit(v[i], i == hc_bit);
    endtask

    task automatic send_data(input logic [W-1:0] v, input logic b2b, input string tag);
        exp_q.push_back({b2b, 1'b0, v});
        tag_q.push_back(tag);
        send_byte(v);
    endtask

    task automatic send_eot(input string tag);
        exp_q.push_back({1'b0, 1'b1, {W{1'b0}}});
        tag_q.push_back(tag);
        send_byte(eot_code);
    endtask

    task automatic idle();
        send_byte({W{1'b1}});
    endtask

    // Observe state right after the edge that sampled the last driven bit.
    task automatic probe(input logic exp_sync, input string tag);
        @(posedge clk);
        #1;
        check({tag, " in_sync"}, {31'd0, in_sync}, {31'd0, exp_sync});
    endtask

    task automatic probe_quiet(input string tag);
        check({tag, " no eot strobe"}, {31'd0, eot_stb}, 32'd0);
        check({tag, " no data strobe"}, {31'd0, char_valid}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; rxd = 1'b1; hunt_cmd = 1'b0;
        sync_pat = SYN; eot_code = EOT;
        repeat (3) @(negedge clk);
        check("R1 in_sync", {31'd0, in_sync}, 32'd0);
        check("R1 char_valid", {31'd0, char_valid}, 32'd0);
        check("R1 eot_stb", {31'd0, eot_stb}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 in_sync after release", {31'd0, in_sync}, 32'd0);

        // R2/R3/R4: odd alignment, lock, back-to-back characters, end code
        send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        idle();
        send_byte(SYN);
        probe(1'b1, "R2");
        send_data(8'hA5, 1'b0, "R4");
        send_data(8'h3C, 1'b1, "R4");
        send_data(8'h01, 1'b1, "R3");
        send_data(8'h80, 1'b1, "R3");
        send_eot("R7");
        probe(1'b0, "R7");

        // R5: sync pattern straddling two characters (0x60 then 0x01)
        idle();
        send_byte(SYN);
        send_data(8'h60, 1'b0, "R5");
        send_data(8'h01, 1'b1, "R5");
        probe(1'b1, "R5");
        send_data(8'h22, 1'b1, "R5");
        send_eot("R7");

        // R6 / R10: second sync drops to hunt; end code while hunting is ignored
        idle();
        send_byte(SYN);
        send_data(8'h55, 1'b0, "R6");
        send_byte(SYN);
        probe(1'b0, "R6");
        send_byte(8'h77);
        send_byte(EOT);
        probe(1'b0, "R10");
        probe_quiet("R10");
        idle();

        // R6: repeated sync run of three, then data
        send_byte(SYN);
        send_byte(SYN);
        probe(1'b0, "R6");
        send_byte(SYN);
        probe(1'b1, "R6");
        send_data(8'h6B, 1'b0, "R6");
        send_eot("R7");

        // R8: hunt command mid-character
        idle();
        send_byte(SYN);
        send_data(8'h5A, 1'b0, "R8");
        send_byte_hc(8'h99, 3);
        probe(1'b0, "R8");
        idle();
        // R8: hunt command on the last bit of an end-code character
        send_byte(SYN);
        send_data(8'h11, 1'b0, "R8");
        send_byte_hc(EOT, W - 1);
        probe(1'b0, "R8");
        probe_quiet("R8");
        idle();
        send_byte(SYN);
        send_data(8'h33, 1'b0, "R8");
        send_eot("R8");
        idle();

        // R9: sync and end codes equal
        eot_code = SYN;
        idle();
        send_byte(SYN);
        send_data(8'h42, 1'b0, "R9");
        send_byte(SYN);
        probe(1'b0, "R9");
        probe_quiet("R9");
        idle();
        eot_code = EOT;

        repeat (20) @(negedge clk);
        check("R10 all expected outputs seen", exp_q.size(), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule